// File: doc/BRIEF.md
# Pass-Through Burst Read Responder

This block sits on the local (add-on) side of a PCI target bridge and services read requests that the bridge forwards through its pass-through port. When the bridge pulls its active-low attention line and reports a read, the responder pulses an address strobe. It captures the forwarded address from the shared data bus on the closing edge of that strobe, then leaves one idle clock so that the bridge can release the bus. After that it pushes words into the bridge's read FIFO.

Each data word is fetched from a local source through a request/valid handshake and held in an output register. The ready strobe is raised only for a clock that actually carries a word, so a slow source produces wait states by itself. The bridge's burst flag, sampled on every completed transfer, decides whether another word follows. The flag drops one transfer early, so a transfer that sees it high is the final one. The responder then releases the data phase and waits for attention and burst to both go inactive before it accepts the next access. The region number is decoded into a one-hot output that stays valid for the whole access.

Top module: `ptrd_responder`

## Requirements
- R1: During and after reset, until an access starts: addr_stb_n, wr_n, sel_n and rdy_n are 1, dq_oe is 0, region_hit is 0 and src_req is 0.
- R2: In the idle state, a clock edge that samples attn_n=0 with dir_wr=0 makes addr_stb_n low for exactly the next clock. The value on dq_in at the edge that ends that clock appears on addr_q afterwards.
- R3: An access marked as a write (dir_wr=1 while attn_n=0) is ignored: no address strobe, no data phase and region_hit stays 0.
- R4: The edge that starts an access sets region_hit to a one-hot value with bit number equal to region (0 to 3). The value is held until the block returns to idle, where it is cleared to 0.
- R5: The clock after the address strobe is a turnaround clock: addr_stb_n=1, wr_n=1 and dq_oe=0.
- R6: From the clock after turnaround until release, wr_n=0, sel_n=0, dq_oe=1, adr_out equals the FIFO_ADR parameter (default 5'h08) and be_out_n is 4'b0000.
- R7: A word is accepted from the source at an edge where src_req=1 and src_valid=1. It is shown on dq_out with rdy_n=0 in the next clock. After a clock with src_req=1 and src_valid=0, rdy_n is 1.
- R8: A transfer is a clock with wr_n=0 and rdy_n=0. If burst_n=0 is sampled at a transfer edge, the data phase continues. Words reach dq_out in the order the source supplied them, with none lost or repeated.
- R9: If burst_n=1 is sampled at a transfer edge, that transfer was the last. In the next clock, wr_n, sel_n and rdy_n are 1, dq_oe is 0 and src_req is 0.
- R10: After release, no new access is accepted while attn_n or burst_n is 0, and region_hit is held. The edge that samples both at 1 returns the block to idle, and a read can start on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Bridge attention, active low; access pending |
| burst_n | input | 1 | Bridge burst flag, active low; more data wanted |
| region | input | 2 | Region number of the pending access |
| dir_wr | input | 1 | 1 = write access, 0 = read access |
| dq_in | input | 32 | Shared data bus as driven by the bridge (address) |
| addr_stb_n | output | 1 | Address strobe to the bridge, active low |
| addr_q | output | 32 | Captured access address |
| wr_n | output | 1 | Write strobe to the bridge FIFO, active low |
| sel_n | output | 1 | Register select to the bridge, active low |
| rdy_n | output | 1 | Ready strobe, active low; completes a data phase |
| adr_out | output | 5 | Bridge register address during the data phase |
| be_out_n | output | 4 | Byte enables to the bridge, active low |
| dq_out | output | 32 | Data word for the shared bus |
| dq_oe | output | 1 | Output enable for dq_out onto the shared bus |
| src_valid | input | 1 | Local source has a word on src_data |
| src_data | input | 32 | Local source data word |
| src_req | output | 1 | Responder can take a word this clock |
| region_hit | output | 4 | One-hot decoded region of the current access |

## Verification
The bench models the bridge. It lowers the burst flag only after the next-to-last transfer, so an off-by-one end detection leaves an extra word or loses the final one, and the scoreboard catches both. Single-word accesses, a source that is valid every second or third clock, and a write access that must be ignored target the ready/valid pairing, a wrongly sensed direction bit and a missing turnaround clock. In the last case the data bus would be enabled right after the address strobe. One access keeps attention low after release, to catch a design that rearms too early and issues a second address strobe.

// File: rtl/ptrd_pkg.sv
package ptrd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_TURN,
    S_DATA,
    S_DONE
  } ptrd_state_e;
endpackage

// File: rtl/ptrd_region_dec.sv
module ptrd_region_dec #(
  parameter int RW = 2,
  localparam int NREG = 1 << RW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            clear,
  input  logic [RW-1:0]   region,
  output logic [NREG-1:0] hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear) hit[i] <= 1'b0;
      else if (load)    hit[i] <= (region == RW'(i));
    end
  end

  p_onehot_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load |=> (hit == (NREG'(1) << $past(region))));
endmodule

// File: rtl/ptrd_datapath.sv
module ptrd_datapath #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_addr,
  input  logic          cap_word,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] src_data,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] dq_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dq_out <= '0;
    end else begin
      if (cap_addr) addr_q <= dq_in;
      if (cap_word) dq_out <= src_data;
    end
  end
endmodule

// File: rtl/ptrd_seq.sv
module ptrd_seq
  import ptrd_pkg::*;
#(
  parameter int AW = 5,
  parameter int BEW = 4,
  parameter logic [AW-1:0] FIFO_ADR = 5'h08
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           attn_n,
  input  logic           burst_n,
  input  logic           dir_wr,
  input  logic           src_valid,
  output logic           src_req,
  output logic           addr_stb_n,
  output logic           wr_n,
  output logic           sel_n,
  output logic           rdy_n,
  output logic           dq_oe,
  output logic [AW-1:0]  adr_out,
  output logic [BEW-1:0] be_out_n,
  output logic           cap_addr,
  output logic           cap_word,
  output logic           load_region,
  output logic           clr_region
);
  ptrd_state_e st;
  logic start, last_xfer, rearm;

  assign start       = (st == S_IDLE) && !attn_n && !dir_wr;
  assign last_xfer   = (st == S_DATA) && !rdy_n && burst_n;
  assign rearm       = (st == S_DONE) && attn_n && burst_n;
  assign src_req     = (st == S_TURN) || ((st == S_DATA) && !last_xfer);
  assign cap_word    = src_req && src_valid;
  assign cap_addr    = (st == S_ADDR);
  assign load_region = start;
  assign clr_region  = rearm;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      addr_stb_n <= 1'b1;
      wr_n       <= 1'b1;
      sel_n      <= 1'b1;
      rdy_n      <= 1'b1;
      dq_oe      <= 1'b0;
      adr_out    <= '0;
      be_out_n   <= '1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st         <= S_ADDR;
          addr_stb_n <= 1'b0;
        end
        S_ADDR: begin
          st         <= S_TURN;
          addr_stb_n <= 1'b1;
        end
        S_TURN: begin
          st       <= S_DATA;
          wr_n     <= 1'b0;
          sel_n    <= 1'b0;
          dq_oe    <= 1'b1;
          adr_out  <= FIFO_ADR;
          be_out_n <= '0;
          rdy_n    <= !src_valid;
        end
        S_DATA: begin
          if (last_xfer) begin
            st       <= S_DONE;
            wr_n     <= 1'b1;
            sel_n    <= 1'b1;
            rdy_n    <= 1'b1;
            dq_oe    <= 1'b0;
            adr_out  <= '0;
            be_out_n <= '1;
          end else begin
            rdy_n <= !src_valid;
          end
        end
        S_DONE: if (rearm) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_gap_r5: assert property (@(posedge clk) disable iff (rst)
    !addr_stb_n |=> (addr_stb_n && wr_n && !dq_oe));
  p_ready_in_data_r6: assert property (@(posedge clk) disable iff (rst)
    !rdy_n |-> (!wr_n && !sel_n && dq_oe));
  p_wait_state_r7: assert property (@(posedge clk) disable iff (rst)
    (src_req && !src_valid) |=> rdy_n);
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !rdy_n && burst_n) |=> (wr_n && sel_n && rdy_n && !dq_oe && !src_req));
  p_ignore_write_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_stb_n && wr_n && dir_wr) |=> addr_stb_n);
  p_hold_done_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE && (!attn_n || !burst_n)) |=> addr_stb_n);
endmodule

// File: rtl/ptrd_responder.sv
module ptrd_responder #(
  parameter int DW = 32,
  parameter int RW = 2,
  parameter int AW = 5,
  parameter logic [AW-1:0] FIFO_ADR = 5'h08,
  localparam int NREG = 1 << RW,
  localparam int BEW = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            attn_n,
  input  logic            burst_n,
  input  logic [RW-1:0]   region,
  input  logic            dir_wr,
  input  logic [DW-1:0]   dq_in,
  output logic            addr_stb_n,
  output logic [DW-1:0]   addr_q,
  output logic            wr_n,
  output logic            sel_n,
  output logic            rdy_n,
  output logic [AW-1:0]   adr_out,
  output logic [BEW-1:0]  be_out_n,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic            src_valid,
  input  logic [DW-1:0]   src_data,
  output logic            src_req,
  output logic [NREG-1:0] region_hit
);
  logic cap_addr, cap_word, load_region, clr_region;

  ptrd_seq #(.AW(AW), .BEW(BEW), .FIFO_ADR(FIFO_ADR)) u_seq (
    .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n), .dir_wr(dir_wr),
    .src_valid(src_valid), .src_req(src_req), .addr_stb_n(addr_stb_n),
    .wr_n(wr_n), .sel_n(sel_n), .rdy_n(rdy_n), .dq_oe(dq_oe),
    .adr_out(adr_out), .be_out_n(be_out_n), .cap_addr(cap_addr),
    .cap_word(cap_word), .load_region(load_region), .clr_region(clr_region)
  );

  ptrd_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .cap_addr(cap_addr), .cap_word(cap_word),
    .dq_in(dq_in), .src_data(src_data), .addr_q(addr_q), .dq_out(dq_out)
  );

  ptrd_region_dec #(.RW(RW)) u_dec (
    .clk(clk), .rst(rst), .load(load_region), .clear(clr_region),
    .region(region), .hit(region_hit)
  );
endmodule

// File: tb/test_ptrd_responder.sv
module test_ptrd_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        attn_n = 1'b1, burst_n = 1'b1, dir_wr = 1'b0;
  logic [1:0]  region = '0;
  logic [31:0] dq_in = '0, src_data = '0;
  logic        src_valid = 1'b0;
  logic        addr_stb_n, wr_n, sel_n, rdy_n, dq_oe, src_req;
  logic [31:0] addr_q, dq_out;
  logic [4:0]  adr_out;
  logic [3:0]  be_out_n, region_hit;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  ptrd_responder i_ptrd_responder (
    .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n), .region(region),
    .dir_wr(dir_wr), .dq_in(dq_in), .addr_stb_n(addr_stb_n), .addr_q(addr_q),
    .wr_n(wr_n), .sel_n(sel_n), .rdy_n(rdy_n), .adr_out(adr_out),
    .be_out_n(be_out_n), .dq_out(dq_out), .dq_oe(dq_oe), .src_valid(src_valid),
    .src_data(src_data), .src_req(src_req), .region_hit(region_hit)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", wd);
      summary();
      $finish;
    end
  end

  // scoreboard monitor: every transfer clock pops one expected word
  always @(negedge clk) begin
    if (!rst && !wr_n && !rdy_n) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 extra transfer", dq_out, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(dq_out == e, "R8 word order", dq_out, e);
      end
    end
  end

  task automatic do_read(input logic [1:0] rg, input logic [31:0] adr,
                         input int n, input int period, input bit hold);
    int completed = 0;
    int cyc = 0;
    int stb_cyc = -10;
    int pushed = 0;
    bit noval = 1'b0;
    bit fin = 1'b0;
    @(negedge clk);
    attn_n = 1'b0; dir_wr = 1'b0; region = rg; dq_in = adr;
    burst_n = (n > 1) ? 1'b0 : 1'b1;
    while (!fin && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (noval) check(rdy_n == 1'b1, "R7 wait state", 32'(rdy_n), 32'h1);
      if (!addr_stb_n) begin
        check(cyc != stb_cyc + 1, "R2 strobe length", 32'(cyc - stb_cyc), 32'h2);
        stb_cyc = cyc;
        check(region_hit == (4'b1 << rg), "R4 region decode", 32'(region_hit), 32'(4'b1 << rg));
      end
      if (cyc == stb_cyc + 1) begin
        check(addr_stb_n && wr_n && !dq_oe, "R5 turnaround",
              {29'h0, addr_stb_n, wr_n, dq_oe}, 32'h6);
        check(addr_q == adr, "R2 address capture", addr_q, adr);
      end
      if (cyc == stb_cyc + 2)
        check(!wr_n && !sel_n && dq_oe && adr_out == 5'h08 && be_out_n == 4'h0,
              "R6 data phase", {20'h0, wr_n, sel_n, dq_oe, adr_out, be_out_n},
              {20'h0, 3'b001, 5'h08, 4'h0});
      if (completed == n) begin
        check(wr_n && sel_n && rdy_n && !dq_oe && !src_req, "R9 release",
              {27'h0, wr_n, sel_n, rdy_n, dq_oe, src_req}, 32'h1C);
        src_valid = 1'b0;
        noval = 1'b0;
        burst_n = 1'b1;
        if (hold) begin
          for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(addr_stb_n && region_hit == (4'b1 << rg), "R10 hold after release",
                  {27'h0, addr_stb_n, region_hit}, {27'h0, 1'b1, 4'b1 << rg});
          end
        end
        attn_n = 1'b1;
        fin = 1'b1;
      end else begin
        burst_n = (completed < n - 1) ? 1'b0 : 1'b1;
        if (!wr_n && !rdy_n) completed++;
        #1;
        if (src_req && (cyc % period == 0)) begin
          src_valid = 1'b1;
          src_data = {adr[15:0], 16'(pushed) ^ 16'h5A00};
          exp_q.push_back(src_data);
          pushed++;
          noval = 1'b0;
        end else begin
          src_valid = 1'b0;
          noval = src_req;
        end
      end
    end
    check(fin, "R8 access completes", 32'(completed), 32'(n));
    check(pushed == n, "R9 words fetched", 32'(pushed), 32'(n));
    @(negedge clk);
    check(region_hit == 4'h0, "R10 back to idle", 32'(region_hit), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(addr_stb_n && wr_n && sel_n && rdy_n && !dq_oe && region_hit == 0 && !src_req,
          "R1 reset state", {25'h0, addr_stb_n, wr_n, sel_n, rdy_n, dq_oe, src_req, |region_hit},
          32'h78);
    rst = 1'b0;
    @(negedge clk);
    check(addr_stb_n && !dq_oe && !src_req, "R1 idle after reset",
          {29'h0, addr_stb_n, dq_oe, src_req}, 32'h4);

    // R3: write access must be ignored
    attn_n = 1'b0; dir_wr = 1'b1; region = 2'd1; burst_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(addr_stb_n && wr_n && !dq_oe && region_hit == 0, "R3 write ignored",
            {27'h0, addr_stb_n, wr_n, dq_oe, |region_hit, 1'b0}, 32'h18);
    end
    attn_n = 1'b1; burst_n = 1'b1; dir_wr = 1'b0;
    @(negedge clk);

    do_read(2'd0, 32'h1000_0040, 4, 1, 1'b0);
    do_read(2'd2, 32'h2000_0100, 1, 1, 1'b0);
    do_read(2'd1, 32'h3000_0200, 5, 2, 1'b0);
    do_read(2'd3, 32'h4000_0300, 3, 3, 1'b1);
    do_read(2'd0, 32'h5000_0400, 2, 1, 1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R8 all words delivered", 32'(exp_q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule